// File: doc/BRIEF.md
# Scalar Move-Merge Writeback Unit

This block works out what a single scalar 64-bit move leaves behind. The destination is either a wide vector register or a 64-bit memory word. Each request gives the encoding class (legacy, VEX or EVEX) and the operand form (register to register, load or store). It also carries the operands:

- the old destination contents;
- bits 127:64 of the first register source;
- the low quadword of the second register source;
- the memory quadword;
- the writemask controls;
- the 4-bit extra register specifier.

The block combines these into one registered result. That result holds the new register value and a write enable for each lane region. It also holds the store word with its valid strobe, and an undefined-opcode fault.

The encoding class and the form decide what happens to the upper lanes. They can be kept, copied from the first source, or zeroed. EVEX forms may also keep or zero the low quadword when the writemask bit is clear. Data moves bit for bit, with no floating-point interpretation. The result appears one cycle after the request is accepted.

Top module: `scalar_move_wb`

## Requirements
- R1: Legacy (enc 0) register form (form 0): bits 63:0 of the result equal the second-source quadword. Every bit above 63 equals the old destination. lane_we is 3'b001, where bit 0 covers bits 63:0, bit 1 covers 127:64 and bit 2 covers VLEN-1:128.
- R2: Legacy load form (form 1): bits 63:0 equal the memory quadword and bits 127:64 are zero. Bits above 127 equal the old destination. lane_we is 3'b011.
- R3: VEX (enc 1) or EVEX (enc 2) register form: bits 63:0 equal the second-source quadword and bits 127:64 equal the first-source upper quadword. Bits above 127 are zero. lane_we is 3'b111.
- R4: VEX or EVEX load form: bits 63:0 equal the memory quadword, every bit above 63 is zero, and lane_we is 3'b111.
- R5: EVEX register and load forms with mask_en=1 and mask_bit=0 use a masked low quadword. With zero_en=0, bits 63:0 keep the old destination and lane_we bit 0 is 0. With zero_en=1, bits 63:0 are zero and lane_we bit 0 is 1. The upper regions follow R3 or R4.
- R6: For legacy and VEX requests, mask_en, mask_bit and zero_en have no effect on any output.
- R7: Store form (form 2): st_data equals the second-source quadword and st_valid is 1. lane_we is 0 and dst_out equals the old destination. An EVEX store with mask_en=1 and mask_bit=0 drives st_valid to 0, whatever zero_en is.
- R8: A VEX or EVEX load or store whose specifier is not 4'b1111 raises ud_fault. A faulting result has lane_we 0, st_valid 0, st_data 0 and dst_out equal to the old destination. Legacy requests and register forms never fault on the specifier.
- R9: The reserved codes enc 3 and form 3 raise ud_fault, with the same suppressed result as R8.
- R10: Data is copied bit-exact, including NaN and denormal patterns. For non-store requests st_data is 0.
- R11: out_valid is high exactly in the cycle after a cycle with in_valid high. After reset, out_valid and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| enc | input | 2 | Encoding class: 0 legacy, 1 VEX, 2 EVEX, 3 reserved |
| form | input | 2 | Operand form: 0 register, 1 load, 2 store, 3 reserved |
| old_dst | input | VLEN | Current destination register contents |
| src1_hi | input | 64 | Bits 127:64 of the first register source |
| src2_lo | input | 64 | Low quadword of the second register source (data source for the store form) |
| mem_data | input | 64 | Memory quadword for loads |
| mask_bit | input | 1 | Writemask bit 0 |
| mask_en | input | 1 | A writemask is present |
| zero_en | input | 1 | Zeroing-masking selected |
| vreg_spec | input | 4 | Extra register specifier field |
| out_valid | output | 1 | Result valid |
| dst_out | output | VLEN | New destination register value |
| lane_we | output | 3 | Write enables for regions 63:0, 127:64, VLEN-1:128 |
| st_valid | output | 1 | Store word should be written |
| st_data | output | 64 | Store word |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
The assertions assume the request fields are stable and meaningful only in cycles where in_valid is high. They also assume the result registers load only on accepted requests, so each property relates an input cycle to the next output cycle. The stimulus changes inputs only at falling edges and drives one request per cycle or idles with in_valid low. It covers all three classes and all three forms, both masking flavours, bad specifiers and reserved codes, so every property sees live antecedents.

// File: rtl/smov_pkg.sv
package smov_pkg;
  localparam int QW = 64;
  localparam int XW = 128;
  localparam int NREG = 3;

  typedef enum logic [1:0] {
    ENC_LEG = 2'd0,
    ENC_VEX = 2'd1,
    ENC_EVX = 2'd2,
    ENC_RSV = 2'd3
  } enc_e;

  typedef enum logic [1:0] {
    FRM_RR  = 2'd0,
    FRM_LD  = 2'd1,
    FRM_ST  = 2'd2,
    FRM_RSV = 2'd3
  } form_e;
endpackage

// File: rtl/smov_fault_chk.sv
module smov_fault_chk
  import smov_pkg::*;
(
  input  enc_e       enc_i,
  input  form_e      form_i,
  input  logic [3:0] spec_i,
  output logic       fault_o
);
  logic rsv_code;
  logic spec_needed;

  always_comb begin
    rsv_code    = (enc_i == ENC_RSV) || (form_i == FRM_RSV);
    spec_needed = ((enc_i == ENC_VEX) || (enc_i == ENC_EVX)) &&
                  ((form_i == FRM_LD) || (form_i == FRM_ST));
    fault_o     = rsv_code || (spec_needed && (spec_i != 4'hF));
  end
endmodule

// File: rtl/smov_lane_calc.sv
module smov_lane_calc
  import smov_pkg::*;
#(
  parameter int VLEN = 512
) (
  input  enc_e             enc_i,
  input  form_e            form_i,
  input  logic [VLEN-1:0]  old_i,
  input  logic [QW-1:0]    src1_hi_i,
  input  logic [QW-1:0]    src2_lo_i,
  input  logic [QW-1:0]    mem_i,
  input  logic             mask_bit_i,
  input  logic             mask_en_i,
  input  logic             zero_en_i,
  output logic [VLEN-1:0]  dst_o,
  output logic [NREG-1:0]  we_o,
  output logic             st_valid_o,
  output logic [QW-1:0]    st_data_o
);
  logic          masked_off;
  logic          is_wide;
  logic [QW-1:0] lo_val;
  logic [QW-1:0] mid_val;
  logic          lo_we;
  logic          mid_we;
  logic          up_clear;
  logic          up_we;

  always_comb begin
    is_wide    = (enc_i == ENC_VEX) || (enc_i == ENC_EVX);
    masked_off = (enc_i == ENC_EVX) && mask_en_i && !mask_bit_i;
    lo_val     = old_i[QW-1:0];
    mid_val    = old_i[XW-1:QW];
    lo_we      = 1'b0;
    mid_we     = 1'b0;
    up_clear   = 1'b0;
    up_we      = 1'b0;
    st_valid_o = 1'b0;
    st_data_o  = '0;
    if ((enc_i != ENC_RSV) && ((form_i == FRM_RR) || (form_i == FRM_LD))) begin
      if (!masked_off) begin
        lo_val = (form_i == FRM_LD) ? mem_i : src2_lo_i;
        lo_we  = 1'b1;
      end else if (zero_en_i) begin
        lo_val = '0;
        lo_we  = 1'b1;
      end
      if (is_wide) begin
        mid_val  = (form_i == FRM_RR) ? src1_hi_i : '0;
        mid_we   = 1'b1;
        up_clear = 1'b1;
        up_we    = 1'b1;
      end else if (form_i == FRM_LD) begin
        mid_val = '0;
        mid_we  = 1'b1;
      end
    end else if ((enc_i != ENC_RSV) && (form_i == FRM_ST)) begin
      st_valid_o = !masked_off;
      st_data_o  = src2_lo_i;
    end
  end

  assign dst_o[QW-1:0]  = lo_val;
  assign dst_o[XW-1:QW] = mid_val;
  assign we_o[0]        = lo_we;
  assign we_o[1]        = mid_we;

  generate
    if (VLEN > XW) begin : g_upper
      assign dst_o[VLEN-1:XW] = up_clear ? '0 : old_i[VLEN-1:XW];
      assign we_o[2]          = up_we;
    end else begin : g_no_upper
      assign we_o[2] = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/smov_out_reg.sv
module smov_out_reg
  import smov_pkg::*;
#(
  parameter int VLEN = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [VLEN-1:0]  dst_d,
  input  logic [NREG-1:0]  we_d,
  input  logic             stv_d,
  input  logic [QW-1:0]    std_d,
  input  logic             flt_d,
  output logic             vld_q,
  output logic [VLEN-1:0]  dst_q,
  output logic [NREG-1:0]  we_q,
  output logic             stv_q,
  output logic [QW-1:0]    std_q,
  output logic             flt_q
);
  logic [VLEN-1:0] dst_n;
  logic [NREG-1:0] we_n;
  logic            stv_n;
  logic [QW-1:0]   std_n;
  logic            flt_n;

  always_comb begin
    dst_n = dst_q;
    we_n  = we_q;
    stv_n = stv_q;
    std_n = std_q;
    flt_n = flt_q;
    if (en_i) begin
      dst_n = dst_d;
      we_n  = we_d;
      stv_n = stv_d;
      std_n = std_d;
      flt_n = flt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dst_q <= '0;
      we_q  <= '0;
      stv_q <= 1'b0;
      std_q <= '0;
      flt_q <= 1'b0;
    end else begin
      vld_q <= en_i;
      dst_q <= dst_n;
      we_q  <= we_n;
      stv_q <= stv_n;
      std_q <= std_n;
      flt_q <= flt_n;
    end
  end
endmodule

// File: rtl/scalar_move_wb.sv
module scalar_move_wb
  import smov_pkg::*;
#(
  parameter int VLEN = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       enc,
  input  logic [1:0]       form,
  input  logic [VLEN-1:0]  old_dst,
  input  logic [63:0]      src1_hi,
  input  logic [63:0]      src2_lo,
  input  logic [63:0]      mem_data,
  input  logic             mask_bit,
  input  logic             mask_en,
  input  logic             zero_en,
  input  logic [3:0]       vreg_spec,
  output logic             out_valid,
  output logic [VLEN-1:0]  dst_out,
  output logic [2:0]       lane_we,
  output logic             st_valid,
  output logic [63:0]      st_data,
  output logic             ud_fault
);
  enc_e            enc_t;
  form_e           form_t;
  logic            flt;
  logic [VLEN-1:0] calc_dst;
  logic [NREG-1:0] calc_we;
  logic            calc_stv;
  logic [QW-1:0]   calc_std;
  logic [VLEN-1:0] fin_dst;
  logic [NREG-1:0] fin_we;
  logic            fin_stv;
  logic [QW-1:0]   fin_std;

  assign enc_t  = enc_e'(enc);
  assign form_t = form_e'(form);

  smov_fault_chk u_fault (
    .enc_i   (enc_t),
    .form_i  (form_t),
    .spec_i  (vreg_spec),
    .fault_o (flt)
  );

  smov_lane_calc #(.VLEN(VLEN)) u_calc (
    .enc_i      (enc_t),
    .form_i     (form_t),
    .old_i      (old_dst),
    .src1_hi_i  (src1_hi),
    .src2_lo_i  (src2_lo),
    .mem_i      (mem_data),
    .mask_bit_i (mask_bit),
    .mask_en_i  (mask_en),
    .zero_en_i  (zero_en),
    .dst_o      (calc_dst),
    .we_o       (calc_we),
    .st_valid_o (calc_stv),
    .st_data_o  (calc_std)
  );

  always_comb begin
    if (flt) begin
      fin_dst = old_dst;
      fin_we  = '0;
      fin_stv = 1'b0;
      fin_std = '0;
    end else begin
      fin_dst = calc_dst;
      fin_we  = calc_we;
      fin_stv = calc_stv;
      fin_std = calc_std;
    end
  end

  smov_out_reg #(.VLEN(VLEN)) u_oreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (in_valid),
    .dst_d  (fin_dst),
    .we_d   (fin_we),
    .stv_d  (fin_stv),
    .std_d  (fin_std),
    .flt_d  (flt),
    .vld_q  (out_valid),
    .dst_q  (dst_out),
    .we_q   (lane_we),
    .stv_q  (st_valid),
    .std_q  (st_data),
    .flt_q  (ud_fault)
  );
endmodule

// File: rtl/smov_chk.sv
module smov_chk #(
  parameter int VLEN = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      enc,
  input logic [1:0]      form,
  input logic [VLEN-1:0] old_dst,
  input logic [63:0]     src2_lo,
  input logic            mask_bit,
  input logic            mask_en,
  input logic [3:0]      vreg_spec,
  input logic            out_valid,
  input logic [VLEN-1:0] dst_out,
  input logic [2:0]      lane_we,
  input logic            st_valid,
  input logic            ud_fault
);
  a_r11_latency_on: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_latency_off: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_legacy_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc == 2'd0 && form == 2'd0) |=>
      (dst_out[VLEN-1:64] == $past(old_dst[VLEN-1:64]) && dst_out[63:0] == $past(src2_lo)));
  a_r4_wide_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (enc == 2'd1 || enc == 2'd2) && form == 2'd1 && vreg_spec == 4'hF) |=>
      (dst_out[VLEN-1:64] == '0 && !ud_fault));
  a_r7_store_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc == 2'd2 && form == 2'd2 && mask_en && !mask_bit) |=> !st_valid);
  a_r7_store_no_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && st_valid) |-> (lane_we == 3'b000));
  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ud_fault) |-> (lane_we == 3'b000 && !st_valid));
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (enc == 2'd3 || form == 2'd3)) |=> ud_fault);
endmodule

bind scalar_move_wb smov_chk #(.VLEN(VLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .enc       (enc),
  .form      (form),
  .old_dst   (old_dst),
  .src2_lo   (src2_lo),
  .mask_bit  (mask_bit),
  .mask_en   (mask_en),
  .vreg_spec (vreg_spec),
  .out_valid (out_valid),
  .dst_out   (dst_out),
  .lane_we   (lane_we),
  .st_valid  (st_valid),
  .ud_fault  (ud_fault)
);

// File: tb/test_scalar_move_wb.sv
module test_scalar_move_wb;
  localparam int VL = 512;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [VL-1:0] dst;
    logic [2:0]    we;
    logic          stv;
    logic [63:0]   std;
    logic          flt;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    enc = '0;
  logic [1:0]    form = '0;
  logic [VL-1:0] old_dst = '0;
  logic [63:0]   src1_hi = '0;
  logic [63:0]   src2_lo = '0;
  logic [63:0]   mem_data = '0;
  logic          mask_bit = 1'b0;
  logic          mask_en = 1'b0;
  logic          zero_en = 1'b0;
  logic [3:0]    vreg_spec = 4'hF;
  logic          out_valid;
  logic [VL-1:0] dst_out;
  logic [2:0]    lane_we;
  logic          st_valid;
  logic [63:0]   st_data;
  logic          ud_fault;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  scalar_move_wb #(.VLEN(VL)) i_scalar_move_wb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc(enc), .form(form),
    .old_dst(old_dst), .src1_hi(src1_hi), .src2_lo(src2_lo), .mem_data(mem_data),
    .mask_bit(mask_bit), .mask_en(mask_en), .zero_en(zero_en), .vreg_spec(vreg_spec),
    .out_valid(out_valid), .dst_out(dst_out), .lane_we(lane_we), .st_valid(st_valid),
    .st_data(st_data), .ud_fault(ud_fault));

  function automatic exp_t model(input logic [1:0] e, input logic [1:0] f,
      input logic [VL-1:0] od, input logic [63:0] s1, input logic [63:0] s2,
      input logic [63:0] md, input logic mb, input logic me, input logic ze,
      input logic [3:0] vs, input string tag);
    exp_t r;
    logic hide;
    r.dst = od; r.we = 3'b000; r.stv = 1'b0; r.std = '0; r.flt = 1'b0; r.tag = tag;
    hide = (e == 2'd2) && me && !mb;
    if (e == 2'd3 || f == 2'd3) r.flt = 1'b1;
    else if (e != 2'd0 && f != 2'd0 && vs != 4'hF) r.flt = 1'b1;
    if (r.flt) return r;
    if (f == 2'd2) begin
      r.stv = !hide;
      r.std = s2;
      return r;
    end
    if (e == 2'd0) begin
      r.dst[63:0] = (f == 2'd1) ? md : s2;
      r.we = (f == 2'd1) ? 3'b011 : 3'b001;
      if (f == 2'd1) r.dst[127:64] = '0;
    end else begin
      r.dst = '0;
      if (f == 2'd0) r.dst[127:64] = s1;
      r.we = 3'b111;
      if (hide) begin
        r.dst[63:0] = ze ? 64'd0 : od[63:0];
        r.we[0] = ze;
      end else begin
        r.dst[63:0] = (f == 2'd1) ? md : s2;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic drive(input logic [1:0] e, input logic [1:0] f, input logic mb,
      input logic me, input logic ze, input logic [3:0] vs, input int seed, input string tag);
    @(negedge clk);
    enc = e; form = f; mask_bit = mb; mask_en = me; zero_en = ze; vreg_spec = vs;
    old_dst  = {8{64'hDEAD_0000_0000_0000 + 64'(seed)}};
    old_dst[63:0] = 64'hC0DE_0000_0000_0000 | 64'(seed);
    src1_hi  = 64'h1111_2222_3333_0000 + 64'(seed);
    src2_lo  = 64'h7FF8_0000_0000_0001 + 64'(seed * 16);
    mem_data = 64'h0000_0000_0000_0001 + 64'(seed << 8);
    in_valid = 1'b1;
    sb.push_back(model(e, f, old_dst, src1_hi, src2_lo, mem_data, mb, me, ze, vs, tag));
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11 unexpected out_valid with empty scoreboard");
      end else begin
        exp_t x;
        x = sb.pop_front();
        check(dst_out === x.dst && lane_we === x.we && st_valid === x.stv &&
              st_data === x.std && ud_fault === x.flt,
              $sformatf("%s dst=%h we=%b stv=%b std=%h flt=%b exp dst=%h we=%b stv=%b std=%h flt=%b",
                x.tag, dst_out, lane_we, st_valid, st_data, ud_fault,
                x.dst, x.we, x.stv, x.std, x.flt));
      end
    end
  end

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && dst_out === '0 && lane_we === 3'b000 && st_valid === 1'b0 &&
          st_data === '0 && ud_fault === 1'b0,
          $sformatf("R11 reset state ov=%b we=%b flt=%b exp all zero", out_valid, lane_we, ud_fault));
    rst_n = 1'b1;
    @(negedge clk);
    // R11: one-cycle latency and idle afterwards
    drive(2'd0, 2'd0, 0, 0, 0, 4'hF, 1, "R1 legacy reg");
    @(negedge clk);
    check(out_valid === 1'b1, $sformatf("R11 out_valid=%b exp 1", out_valid));
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, $sformatf("R11 out_valid=%b exp 0", out_valid));
    // back-to-back stream
    drive(2'd0, 2'd1, 0, 0, 0, 4'h0, 2, "R2 legacy load, spec ignored R8");
    drive(2'd1, 2'd0, 0, 0, 0, 4'h3, 3, "R3 vex reg, spec ignored R8");
    drive(2'd2, 2'd0, 1, 1, 0, 4'hF, 4, "R3 evex reg mask set");
    drive(2'd1, 2'd1, 0, 0, 0, 4'hF, 5, "R4 vex load");
    drive(2'd2, 2'd1, 0, 0, 0, 4'hF, 6, "R4 evex load no mask");
    drive(2'd2, 2'd0, 0, 1, 0, 4'hF, 7, "R5 evex reg merge");
    drive(2'd2, 2'd0, 0, 1, 1, 4'hF, 8, "R5 evex reg zeroing");
    drive(2'd2, 2'd1, 0, 1, 0, 4'hF, 9, "R5 evex load merge");
    drive(2'd2, 2'd1, 0, 1, 1, 4'hF, 10, "R5 evex load zeroing");
    drive(2'd1, 2'd0, 0, 1, 1, 4'hF, 11, "R6 vex reg mask inputs ignored");
    drive(2'd0, 2'd1, 0, 1, 1, 4'hF, 12, "R6 legacy load mask inputs ignored");
    drive(2'd0, 2'd2, 0, 1, 1, 4'hF, 13, "R6 legacy store mask inputs ignored");
    drive(2'd1, 2'd2, 0, 0, 0, 4'hF, 14, "R7 vex store");
    drive(2'd2, 2'd2, 0, 1, 0, 4'hF, 15, "R7 evex store masked");
    drive(2'd2, 2'd2, 0, 1, 1, 4'hF, 16, "R7 evex store masked zero_en");
    drive(2'd2, 2'd2, 1, 1, 0, 4'hF, 17, "R7 evex store mask set");
    drive(2'd1, 2'd1, 0, 0, 0, 4'hE, 18, "R8 vex load bad spec");
    drive(2'd2, 2'd2, 1, 0, 0, 4'h7, 19, "R8 evex store bad spec");
    drive(2'd3, 2'd0, 0, 0, 0, 4'hF, 20, "R9 reserved enc");
    drive(2'd0, 2'd3, 0, 0, 0, 4'hF, 21, "R9 reserved form");
    drive(2'd1, 2'd0, 0, 0, 0, 4'hF, 22, "R10 NaN pattern reg");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(sb.size() == 0, $sformatf("R11 leftover items=%0d exp 0", sb.size()));
    done = 1;
    report();
  end
endmodule